// File: doc/BRIEF.md
# Routable Level Interrupt Controller

This block gathers thirty-two level-sensitive interrupt sources and steers each one onto one of fifteen output interrupt lines. Software selects the target line of every source through a 4-bit code held in a bank of routing registers. Code zero parks the source on no line. A global enable mask decides which sources may take part at all.

A read-only status word shows the raw level of every source. Software finds the pending sources by ANDing the status word with the mask. Each output line is registered and stays high for as long as at least one enabled source routed to it is held high.

Access is through a plain synchronous register port. A write takes effect on the rising clock edge where `we_i` is high. Reads are combinational from the address.

Top module: `lvl_irq_router`

## Requirements
- R1: While `rst_ni` is low and after it rises, the mask and all four routing registers read 0 and `irq_o` is 0.
- R2: Byte offset 0x00 holds the 32-bit enable mask. A write there is stored on the strobed edge and reads back unchanged. Bit n enables source n when it is 1 and blocks it when it is 0.
- R3: Offset 0x04 reads back the current levels of `irq_i` in the same cycle. Writes to 0x04 change no register and no output.
- R4: Offsets 0x08, 0x0C, 0x10 and 0x14 hold routing words 0, 1, 2 and 3. Each is written and read back as a full 32-bit word.
- R5: Source n takes its code from routing word 3 − floor(n/8), at bits 4·(n mod 8)+3 down to 4·(n mod 8). Source 31 is therefore bits 31:28 of word 0, and source 0 is bits 3:0 of word 3.
- R6: Code 0 connects the source to no output. Code c in 1..15 connects it to output bit c−1.
- R7: A source whose mask bit is 0 never drives any output, whatever its level and code.
- R8: Output bit k is the OR, over all sources, of (level AND mask bit AND code equal to k+1). It stays high while such a source is held high and falls once none is.
- R9: `irq_o` is registered. A change on `irq_i` shows on `irq_o` after the next rising edge. A register write shows on `irq_o` one edge after the edge that stores it.
- R10: Reads at any offset other than the six mapped ones return 0. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte offset of the accessed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_i | input | 32 | Level interrupt sources |
| irq_o | output | 15 | Routed interrupt lines |

## Verification
The bench drives source 31 through word 0 and source 0 through word 3, at the outermost nibbles. A design that did not reverse the word order, or that placed the nibbles the wrong way, would raise the wrong line or no line at all.

It drives code 15 onto the top output line and code 0 with every source high. An off-by-one in code decoding would shift lines or would let parked sources through.

It checks that an output is delayed by exactly one edge after a routing write. It also checks that writes to the status offset and to unmapped offsets change nothing. A long random phase mixes writes with toggling levels and compares every cycle against a behavioural model, which exposes missing OR terms or mask leaks when several sources share a line.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_CODE_W = 4;
  localparam int unsigned DEF_NUM_IN = 32;
  localparam int unsigned DEF_ADDR_W = 8;

  localparam int unsigned OFF_MASK = 'h00;
  localparam int unsigned OFF_STAT = 'h04;
  localparam int unsigned OFF_RT0  = 'h08;
  localparam int unsigned RT_STEP  = 4;
endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
  import irc_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned NUM_IN = DEF_NUM_IN,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned FIELDS = DATA_W / CODE_W,
  localparam int unsigned NUM_RT = NUM_IN / FIELDS
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_IN-1:0]              irq_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NUM_IN-1:0]              mask_o,
  output logic [NUM_RT-1:0][DATA_W-1:0]  route_o
);
  logic [DATA_W-1:0]             mask_q;
  logic [NUM_RT-1:0][DATA_W-1:0] rt_q;
  logic                          mask_hit, stat_hit;
  logic [NUM_RT-1:0]             rt_hit;

  assign mask_hit = (addr_i == ADDR_W'(OFF_MASK));
  assign stat_hit = (addr_i == ADDR_W'(OFF_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mask_q <= '0;
    else if (we_i && mask_hit)  mask_q <= wdata_i;
  end

  for (genvar r = 0; r < NUM_RT; r++) begin : g_rt
    assign rt_hit[r] = (addr_i == ADDR_W'(OFF_RT0 + RT_STEP * r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 rt_q[r] <= '0;
      else if (we_i && rt_hit[r])  rt_q[r] <= wdata_i;
    end
  end

  // Hits are mutually exclusive; unmapped offsets fall through to zero.
  always_comb begin
    rdata_o = '0;
    if (mask_hit) rdata_o = mask_q;
    if (stat_hit) rdata_o = DATA_W'(irq_i);
    for (int r = 0; r < NUM_RT; r++) begin
      if (rt_hit[r]) rdata_o = rt_q[r];
    end
  end

  assign mask_o  = mask_q[NUM_IN-1:0];
  assign route_o = rt_q;
endmodule

// File: rtl/irc_field_unpack.sv
module irc_field_unpack
  import irc_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned NUM_IN = DEF_NUM_IN,
  localparam int unsigned FIELDS = DATA_W / CODE_W,
  localparam int unsigned NUM_RT = NUM_IN / FIELDS
) (
  input  logic [NUM_RT-1:0][DATA_W-1:0]  route_i,
  output logic [NUM_IN-1:0][CODE_W-1:0]  code_o
);
  // Word order is reversed: the highest sources sit in the lowest word.
  for (genvar n = 0; n < NUM_IN; n++) begin : g_src
    localparam int unsigned WORD = NUM_RT - 1 - n / FIELDS;
    localparam int unsigned LSB  = (n % FIELDS) * CODE_W;
    assign code_o[n] = route_i[WORD][LSB +: CODE_W];
  end
endmodule

// File: rtl/irc_out_merge.sv
module irc_out_merge
  import irc_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned NUM_IN = DEF_NUM_IN,
  localparam int unsigned NUM_OUT = (1 << CODE_W) - 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_IN-1:0]             irq_i,
  input  logic [NUM_IN-1:0]             mask_i,
  input  logic [NUM_IN-1:0][CODE_W-1:0] code_i,
  output logic [NUM_OUT-1:0]            irq_o
);
  logic [NUM_IN-1:0]  live;
  logic [NUM_OUT-1:0] hit_d, irq_q;

  assign live = irq_i & mask_i;

  // Code 0 matches no output line.
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic [NUM_IN-1:0] sel;
    for (genvar n = 0; n < NUM_IN; n++) begin : g_in
      assign sel[n] = (code_i[n] == CODE_W'(k + 1));
    end
    assign hit_d[k] = |(live & sel);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= hit_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import irc_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned NUM_IN = DEF_NUM_IN,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned FIELDS  = DATA_W / CODE_W,
  localparam int unsigned NUM_RT  = NUM_IN / FIELDS,
  localparam int unsigned NUM_OUT = (1 << CODE_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_IN-1:0]  irq_i,
  output logic [NUM_OUT-1:0] irq_o
);
  logic [NUM_IN-1:0]             mask_w;
  logic [NUM_RT-1:0][DATA_W-1:0] route_w;
  logic [NUM_IN-1:0][CODE_W-1:0] code_w;

  irc_regfile #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .NUM_IN(NUM_IN), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .irq_i   (irq_i),
    .rdata_o (rdata_o),
    .mask_o  (mask_w),
    .route_o (route_w)
  );

  irc_field_unpack #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .NUM_IN(NUM_IN)
  ) u_unpack (
    .route_i (route_w),
    .code_o  (code_w)
  );

  irc_out_merge #(
    .CODE_W(CODE_W), .NUM_IN(NUM_IN)
  ) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .mask_i (mask_w),
    .code_i (code_w),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_IN  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_OUT = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_IN-1:0]  irq_i,
  input logic [NUM_OUT-1:0] irq_o,
  input logic [NUM_IN-1:0]  mask_i
);
  logic unmapped;
  assign unmapped = (addr_i > ADDR_W'('h14)) || (addr_i[1:0] != 2'b00);

  AST_MASK_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> (mask_i == $past(wdata_i[NUM_IN-1:0]))); // R2

  AST_STATUS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'('h04)) |-> (rdata_o == DATA_W'(irq_i))); // R3

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> (irq_o == '0)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == '0) |=> (irq_o == '0)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> (rdata_o == '0)); // R10
endmodule

bind lvl_irq_router irc_checker #(
  .DATA_W(DATA_W), .NUM_IN(NUM_IN), .ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_i   (irq_i),
  .irq_o   (irq_o),
  .mask_i  (mask_w)
);

// File: tb/sim_lvl_irq_router.sv
module sim_lvl_irq_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] irq = '0;
  logic [31:0] rdata;
  logic [14:0] irq_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] mask_m;
  logic [31:0] rt_m [4];
  logic [14:0] exp_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .irq_o(irq_out)
  );

  function automatic logic [14:0] route_of(logic [31:0] lv);
    logic [14:0] r = '0;
    for (int n = 0; n < 32; n++) begin
      int c = int'((rt_m[3 - n/8] >> (4*(n%8))) & 32'hF);
      if (lv[n] && mask_m[n] && c != 0) r[c-1] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] read_of(logic [7:0] a);
    case (a)
      8'h00: return mask_m;
      8'h04: return irq;
      8'h08: return rt_m[0];
      8'h0C: return rt_m[1];
      8'h10: return rt_m[2];
      8'h14: return rt_m[3];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [7:0] a);
    if (a == 8'h00) return "R2";
    if (a == 8'h04) return "R3";
    if (a == 8'h08 || a == 8'h0C || a == 8'h10 || a == 8'h14) return "R4";
    return "R10";
  endfunction

  // Reference model: output uses pre-edge register state and current levels.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_m = '0;
      for (int i = 0; i < 4; i++) rt_m[i] = '0;
      exp_o = '0;
    end else begin
      exp_o = route_of(irq);
      if (we) begin
        case (addr)
          8'h00: mask_m = wdata;
          8'h08: rt_m[0] = wdata;
          8'h0C: rt_m[1] = wdata;
          8'h10: rt_m[2] = wdata;
          8'h14: rt_m[3] = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison at the falling edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      check("R1", 32'(irq_out), 32'h0);
    end else begin
      check("R8", 32'(irq_out), 32'(exp_o));
      check(read_tag(addr), rdata, read_of(addr));
    end
  end

  task automatic step(logic w, logic [7:0] a, logic [31:0] d, logic [31:0] lv);
    @(negedge clk); #1;
    we = w; addr = a; wdata = d; irq = lv;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    irq = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 32'(irq_out), 32'h0);
    @(negedge clk); #1; rst_n = 1'b1;
    // R1: registers read zero after reset
    step(1'b0, 8'h00, '0, 32'hFFFF_FFFF); after_edge();
    check("R1", rdata, 32'h0);
    step(1'b0, 8'h14, '0, 32'hFFFF_FFFF); after_edge();
    check("R1", rdata, 32'h0);
    // R6: all enabled but parked on code 0
    step(1'b1, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF); after_edge();
    step(1'b0, 8'h00, '0, 32'hFFFF_FFFF); after_edge();
    check("R6", 32'(irq_out), 32'h0);
    // R5: source 31 in word 0 bits 31:28, code 1 -> line 0
    step(1'b1, 8'h00, 32'h8000_0000, 32'h0); after_edge();
    step(1'b1, 8'h08, 32'h1000_0000, 32'h0); after_edge();
    step(1'b0, 8'h08, '0, 32'h8000_0000); after_edge();
    check("R5", 32'(irq_out), 32'h0001);
    // R5/R6: source 0 in word 3 bits 3:0, code 15 -> line 14
    step(1'b1, 8'h00, 32'h8000_0001, 32'h8000_0000); after_edge();
    step(1'b1, 8'h14, 32'h0000_000F, 32'h8000_0000); after_edge();
    step(1'b0, 8'h14, '0, 32'h8000_0001); after_edge();
    check("R6", 32'(irq_out), 32'h4001);
    // R7: mask blocks source 0
    step(1'b1, 8'h00, 32'h8000_0000, 32'h8000_0001); after_edge();
    step(1'b0, 8'h00, '0, 32'h8000_0001); after_edge();
    check("R7", 32'(irq_out), 32'h0001);
    // R8: level drops, output follows
    step(1'b0, 8'h00, '0, 32'h0); after_edge();
    check("R8", 32'(irq_out), 32'h0);
    // R9: source 23 (word 1 bits 31:28) code 3 -> line 2, one edge of delay
    step(1'b1, 8'h00, 32'h0080_0000, 32'h0080_0000); after_edge();
    step(1'b1, 8'h0C, 32'h3000_0000, 32'h0080_0000); after_edge();
    check("R9", 32'(irq_out), 32'h0);
    step(1'b0, 8'h0C, '0, 32'h0080_0000); after_edge();
    check("R9", 32'(irq_out), 32'h0004);
    // R3: status ignores writes
    step(1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0080_0000); after_edge();
    step(1'b0, 8'h04, '0, 32'h0080_0000); after_edge();
    check("R3", rdata, 32'h0080_0000);
    check("R3", 32'(irq_out), 32'h0004);
    // R10: unmapped write and read
    step(1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0080_0000); after_edge();
    check("R10", rdata, 32'h0);
    step(1'b0, 8'h00, '0, 32'h0080_0000); after_edge();
    check("R10", rdata, 32'h0080_0000);
    // Random phase, compared each cycle by the model.
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = 8'(($urandom % 7) * 4);
      if (($urandom % 16) == 0) a = 8'($urandom);
      step(($urandom % 3) == 0, a, $urandom, $urandom & $urandom);
    end
    step(1'b0, 8'h00, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    done = 1'b1;
    finish_run();
  end
endmodule